// File: doc/BRIEF.md
# Planar Video Memory Datapath

This block connects a byte-wide CPU memory port to four 8-bit bitplanes that share one byte offset. The planes are held in internal storage. A memory-map select chooses the CPU address window, and the offset within that window addresses all four planes at once. A CPU read does two things: it loads one latch per plane, and it returns one plane byte. A CPU write builds a new byte for each plane from the CPU data, the set/reset colour and the latches. It passes them through a rotator, a logical operation and a bit mask, then stores the results in the planes that the plane write mask enables.

All configuration arrives as plain register inputs: write mode, odd/even steering, rotate count, logical op, set/reset, enable set/reset, bit mask, plane write mask and read plane select. Each plane holds 2^OFS_W bytes. The in-window offset is truncated to OFS_W bits, so larger windows alias onto the stored range.

Top module: `planar_vram`

## Requirements
- R1: While `rst_n` is low, `rd_valid` and `rd_data` are 0 and all four latches are cleared to 0.
- R2: Map select 1 decodes 0xA0000..0xAFFFF. Map select 0 decodes 0xA0000..0xBFFFF. Map select 3 decodes 0xB8000..0xBFFFF. Map select 2 decodes nothing. The offset is the address minus the window base, and its low OFS_W bits are used. A read outside the window returns 0xFF and leaves the latches unchanged. A write outside the window changes no plane.
- R3: A read inside the window loads latch p with the byte at the undivided offset in plane p, for p = 0..3.
- R4: A read returns the byte of plane `cfg_rd_plane`. When `cfg_odd_even` is 1, address bit 0 is ORed into the plane number and cleared from the offset.
- R5: In write mode 0 (`cfg_wr_mode`=0), the CPU data is rotated right by `cfg_rot`. The source for plane p is `cfg_sr[p]` replicated to 8 bits when `cfg_sr_en[p]`=1, and the rotated data otherwise.
- R6: `cfg_op` combines the source with the latch: 0 replace, 1 AND, 2 OR, 3 XOR.
- R7: In write mode 2, CPU data bit p replicated to 8 bits is the source for plane p, and the mask is `cfg_bit_mask`.
- R8: In write mode 3, the mask is `cfg_bit_mask` ANDed with the rotated CPU data, and `cfg_sr[p]` replicated is the source for plane p.
- R9: In write mode 1, every enabled plane receives its latch byte unchanged.
- R10: Plane p is written only when `cfg_plane_en[p]`=1. When `cfg_odd_even` is 1, an odd address writes only planes 1 and 3 and an even address only planes 0 and 2, with address bit 0 cleared from the offset.
- R11: In write modes 0, 2 and 3, bit positions outside the effective mask take the latch value of that plane.
- R12: Every read request (`cpu_req`=1, `cpu_we`=0) raises `rd_valid` with its data in the following cycle, and no other cycle raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request this cycle |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cfg_map_sel | input | 2 | Address window select |
| cfg_wr_mode | input | 2 | Write mode 0..3 |
| cfg_odd_even | input | 1 | Odd/even plane steering |
| cfg_rot | input | 3 | Right-rotate count |
| cfg_op | input | 2 | Logical op |
| cfg_sr | input | 4 | Set/reset colour, one bit per plane |
| cfg_sr_en | input | 4 | Set/reset enable per plane (mode 0) |
| cfg_bit_mask | input | 8 | Bit positions that may change |
| cfg_plane_en | input | 4 | Plane write mask |
| cfg_rd_plane | input | 2 | Plane returned on reads |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
Most internal faults in this block surface only through later reads. A wrong latch or a misdecoded offset changes nothing at the ports until a write in mode 1 or with a partial mask merges that latch into a plane, and a following read of that plane shows it two or more cycles later. The bench therefore keeps its own model of every plane and latch, and reads each plane back after each write it checks. A steering or window fault shows up on the first such read-back. A latency fault shows up at once as a `rd_valid` with no expected item queued, or as an item left in the queue.

// File: rtl/planar_pkg.sv
package planar_pkg;
  localparam int NPLANE = 4;

  typedef logic [7:0] pbyte_t;
  typedef logic [NPLANE-1:0][7:0] plane_vec_t;

  typedef enum logic [1:0] {
    OP_REPLACE = 2'd0,
    OP_AND     = 2'd1,
    OP_OR      = 2'd2,
    OP_XOR     = 2'd3
  } op_e;

  function automatic pbyte_t ror8(input pbyte_t v, input logic [2:0] n);
    logic [15:0] t;
    t = {v, v} >> n;
    return t[7:0];
  endfunction
endpackage

// File: rtl/planar_win.sv
module planar_win #(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        map_sel,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] rel;

  always_comb begin
    case (map_sel)
      2'd0:    begin base = ADDR_W'(20'hA0000); span = ADDR_W'(20'h20000); end
      2'd1:    begin base = ADDR_W'(20'hA0000); span = ADDR_W'(20'h10000); end
      2'd3:    begin base = ADDR_W'(20'hB8000); span = ADDR_W'(20'h08000); end
      default: begin base = '0;                 span = '0;                 end
    endcase
    rel = addr - base;
    hit = (span != '0) && (addr >= base) && (rel < span);
    ofs = rel[OFS_W-1:0];
  end
endmodule

// File: rtl/planar_merge.sv
module planar_merge
  import planar_pkg::*;
(
  input  logic [1:0]  wr_mode,
  input  logic [2:0]  rot,
  input  logic [1:0]  op,
  input  logic [3:0]  sr,
  input  logic [3:0]  sr_en,
  input  pbyte_t      bit_mask,
  input  pbyte_t      data,
  input  plane_vec_t  latch,
  output plane_vec_t  result
);
  pbyte_t rdata;
  assign rdata = ror8(data, rot);

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    pbyte_t src, msk, comb;
    always_comb begin
      case (wr_mode)
        2'd0: begin
          src = sr_en[p] ? {8{sr[p]}} : rdata;
          msk = bit_mask;
        end
        2'd2: begin
          src = {8{data[p]}};
          msk = bit_mask;
        end
        2'd3: begin
          src = {8{sr[p]}};
          msk = bit_mask & rdata;
        end
        default: begin
          src = latch[p];
          msk = 8'h00;
        end
      endcase
      case (op_e'(op))
        OP_AND:  comb = src & latch[p];
        OP_OR:   comb = src | latch[p];
        OP_XOR:  comb = src ^ latch[p];
        default: comb = src;
      endcase
      result[p] = (comb & msk) | (latch[p] & ~msk);
    end
  end
endmodule

// File: rtl/planar_store.sv
module planar_store
  import planar_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       we,
  input  logic [OFS_W-1:0] wr_ofs,
  input  plane_vec_t       wdata,
  input  logic             ld_en,
  input  logic [OFS_W-1:0] ld_ofs,
  input  logic             rd_hit,
  input  logic             rd_miss,
  input  logic [1:0]       rd_plane,
  input  logic [OFS_W-1:0] rd_ofs,
  output plane_vec_t       latch_q,
  output logic             rd_valid_q,
  output pbyte_t           rd_data_q
);
  localparam int DEPTH = 1 << OFS_W;

  pbyte_t     rd_byte [NPLANE];
  pbyte_t     ld_byte [NPLANE];
  plane_vec_t latch_d;
  logic       rd_valid_d;
  pbyte_t     rd_data_d;

  for (genvar p = 0; p < NPLANE; p++) begin : g_bank
    pbyte_t bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we[p]) bank[wr_ofs] <= wdata[p];
    end
    assign rd_byte[p] = bank[rd_ofs];
    assign ld_byte[p] = bank[ld_ofs];
  end

  always_comb begin
    for (int p = 0; p < NPLANE; p++)
      latch_d[p] = ld_en ? ld_byte[p] : latch_q[p];
    rd_valid_d = rd_hit | rd_miss;
    rd_data_d  = rd_data_q;
    if (rd_hit)       rd_data_d = rd_byte[rd_plane];
    else if (rd_miss) rd_data_d = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      latch_q    <= latch_d;
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
    end
  end

  AST_READ_HIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && we == 4'b0000) |=> rd_data_q == $past(rd_byte[rd_plane])); // R4
endmodule

// File: rtl/planar_vram.sv
module planar_vram
  import planar_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [1:0]        cfg_map_sel,
  input  logic [1:0]        cfg_wr_mode,
  input  logic              cfg_odd_even,
  input  logic [2:0]        cfg_rot,
  input  logic [1:0]        cfg_op,
  input  logic [3:0]        cfg_sr,
  input  logic [3:0]        cfg_sr_en,
  input  logic [7:0]        cfg_bit_mask,
  input  logic [3:0]        cfg_plane_en,
  input  logic [1:0]        cfg_rd_plane,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic             win_hit;
  logic [OFS_W-1:0] win_ofs;
  logic [OFS_W-1:0] eff_ofs;
  logic             rd_go, rd_miss, wr_go;
  logic [1:0]       rd_plane;
  logic [3:0]       steer, plane_we;
  plane_vec_t       latch_q, merged;
  pbyte_t           eff_mask;

  planar_win #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_win (
    .addr(cpu_addr), .map_sel(cfg_map_sel), .hit(win_hit), .ofs(win_ofs)
  );

  assign rd_go   = cpu_req & ~cpu_we & win_hit;
  assign rd_miss = cpu_req & ~cpu_we & ~win_hit;
  assign wr_go   = cpu_req & cpu_we & win_hit;
  assign eff_ofs = cfg_odd_even ? {win_ofs[OFS_W-1:1], 1'b0} : win_ofs;
  assign rd_plane = cfg_rd_plane | {1'b0, cfg_odd_even & win_ofs[0]};

  always_comb begin
    if (!cfg_odd_even)   steer = 4'b1111;
    else if (win_ofs[0]) steer = 4'b1010;
    else                 steer = 4'b0101;
    plane_we = wr_go ? (steer & cfg_plane_en) : 4'b0000;
  end

  planar_merge i_merge (
    .wr_mode(cfg_wr_mode), .rot(cfg_rot), .op(cfg_op), .sr(cfg_sr),
    .sr_en(cfg_sr_en), .bit_mask(cfg_bit_mask), .data(cpu_wdata),
    .latch(latch_q), .result(merged)
  );

  planar_store #(.OFS_W(OFS_W)) i_store (
    .clk(clk), .rst_n(rst_n), .we(plane_we), .wr_ofs(eff_ofs), .wdata(merged),
    .ld_en(rd_go), .ld_ofs(win_ofs), .rd_hit(rd_go), .rd_miss(rd_miss),
    .rd_plane(rd_plane), .rd_ofs(eff_ofs), .latch_q(latch_q),
    .rd_valid_q(rd_valid), .rd_data_q(rd_data)
  );

  assign eff_mask = (cfg_wr_mode == 2'd3) ? (cfg_bit_mask & ror8(cpu_wdata, cfg_rot))
                                          : cfg_bit_mask;

  AST_MISS_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |=> (rd_valid && rd_data == 8'hFF)); // R2
  AST_MISS_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !win_hit) |=> $stable(latch_q)); // R2
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we) |=> rd_valid); // R12
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && !cpu_we) |=> !rd_valid); // R12
  AST_PLANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_we & ~cfg_plane_en) == 4'b0000); // R10
  AST_ODD_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && cfg_odd_even && cpu_addr[0]) |-> (!plane_we[0] && !plane_we[2])); // R10
  AST_COPY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && cfg_wr_mode == 2'd1) |-> merged == latch_q); // R9

  for (genvar p = 0; p < NPLANE; p++) begin : g_keep
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && cfg_wr_mode != 2'd1) |-> (((merged[p] ^ latch_q[p]) & ~eff_mask) == 8'h00)); // R11
  end
endmodule

// File: tb/test_planar_vram.sv
module test_planar_vram;
  localparam int ADDR_W = 20;
  localparam int OFS_W  = 8;
  localparam int DEPTH  = 1 << OFS_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpu_req, cpu_we;
  logic [ADDR_W-1:0] cpu_addr;
  logic [7:0]        cpu_wdata;
  logic [1:0]        cfg_map_sel, cfg_wr_mode, cfg_op, cfg_rd_plane;
  logic              cfg_odd_even;
  logic [2:0]        cfg_rot;
  logic [3:0]        cfg_sr, cfg_sr_en, cfg_plane_en;
  logic [7:0]        cfg_bit_mask;
  logic              rd_valid;
  logic [7:0]        rd_data;

  always #5 clk = ~clk;

  planar_vram #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_planar_vram (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cfg_map_sel(cfg_map_sel),
    .cfg_wr_mode(cfg_wr_mode), .cfg_odd_even(cfg_odd_even), .cfg_rot(cfg_rot),
    .cfg_op(cfg_op), .cfg_sr(cfg_sr), .cfg_sr_en(cfg_sr_en),
    .cfg_bit_mask(cfg_bit_mask), .cfg_plane_en(cfg_plane_en),
    .cfg_rd_plane(cfg_rd_plane), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  logic [7:0] mdl [4][DEPTH];
  logic [7:0] mlat [4];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic void decode(input logic [ADDR_W-1:0] a, input logic [1:0] ms,
                                 output bit hit, output logic [OFS_W-1:0] o);
    int b, s;
    case (ms)
      2'd0: begin b = 'hA0000; s = 'h20000; end
      2'd1: begin b = 'hA0000; s = 'h10000; end
      2'd3: begin b = 'hB8000; s = 'h08000; end
      default: begin b = 0; s = 0; end
    endcase
    hit = (int'(a) >= b) && (int'(a) < b + s);
    o = OFS_W'(int'(a) - b);
  endfunction

  function automatic logic [7:0] rotr(input logic [7:0] v, input int n);
    return (v >> n) | (v << (8 - n));
  endfunction

  task automatic do_rd(input logic [ADDR_W-1:0] a, input string tag);
    bit hit; logic [OFS_W-1:0] o; int pl;
    @(negedge clk);
    decode(a, cfg_map_sel, hit, o);
    if (hit) begin
      for (int p = 0; p < 4; p++) mlat[p] = mdl[p][o];
      pl = int'(cfg_rd_plane) | ((cfg_odd_even && o[0]) ? 1 : 0);
      if (cfg_odd_even) o[0] = 1'b0;
      exp_q.push_back(mdl[pl][o]);
    end else begin
      exp_q.push_back(8'hFF);
    end
    tag_q.push_back(tag);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(posedge clk); #1 cpu_req = 1'b0;
  endtask

  task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bit hit; logic [OFS_W-1:0] o; logic [7:0] src, msk, cmb, res, rd;
    logic [3:0] en;
    @(negedge clk);
    decode(a, cfg_map_sel, hit, o);
    if (hit) begin
      rd = rotr(d, int'(cfg_rot));
      en = cfg_plane_en;
      if (cfg_odd_even) begin
        en = en & (o[0] ? 4'b1010 : 4'b0101);
        o[0] = 1'b0;
      end
      for (int p = 0; p < 4; p++) begin
        if (cfg_wr_mode == 2'd1) res = mlat[p];
        else begin
          if (cfg_wr_mode == 2'd0) begin
            src = cfg_sr_en[p] ? {8{cfg_sr[p]}} : rd; msk = cfg_bit_mask;
          end else if (cfg_wr_mode == 2'd2) begin
            src = {8{d[p]}}; msk = cfg_bit_mask;
          end else begin
            src = {8{cfg_sr[p]}}; msk = cfg_bit_mask & rd;
          end
          case (cfg_op)
            2'd1: cmb = src & mlat[p];
            2'd2: cmb = src | mlat[p];
            2'd3: cmb = src ^ mlat[p];
            default: cmb = src;
          endcase
          res = (cmb & msk) | (mlat[p] & ~msk);
        end
        if (en[p]) mdl[p][o] = res;
      end
    end
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1 cpu_req = 1'b0;
  endtask

  task automatic read_planes(input logic [ADDR_W-1:0] a, input string tag);
    logic oe;
    oe = cfg_odd_even; cfg_odd_even = 1'b0;
    for (int p = 0; p < 4; p++) begin
      cfg_rd_plane = 2'(p);
      do_rd(a, tag);
    end
    cfg_odd_even = oe;
  endtask

  task automatic plain_cfg();
    cfg_map_sel = 2'd1; cfg_wr_mode = 2'd0; cfg_odd_even = 1'b0; cfg_rot = 3'd0;
    cfg_op = 2'd0; cfg_sr = 4'h0; cfg_sr_en = 4'h0; cfg_bit_mask = 8'hFF;
    cfg_plane_en = 4'hF; cfg_rd_plane = 2'd0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R12 unexpected rd_valid", rd_data, 8'h00);
      else begin
        logic [7:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      check(1'b0, "watchdog", 8'h00, 8'h00);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    plain_cfg();
    for (int p = 0; p < 4; p++) mlat[p] = 8'h00;
    rst_n = 1'b0;
    #23;
    check(rd_valid == 1'b0, "R1 rd_valid in reset", {7'd0, rd_valid}, 8'h00);
    check(rd_data == 8'h00, "R1 rd_data in reset", rd_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R1: latches start at zero, copied out by write mode 1
    cfg_wr_mode = 2'd1; do_wr(20'hA0040, 8'h00);
    cfg_wr_mode = 2'd0; read_planes(20'hA0040, "R1 reset latch");

    // fill planes with distinct bytes
    for (int p = 0; p < 4; p++) begin
      cfg_plane_en = 4'(1 << p);
      for (int k = 0; k < 32; k++) do_wr(20'hA0000 + 20'(k), 8'((p << 5) + k) ^ 8'h5A);
    end
    cfg_plane_en = 4'hF;

    // R4 plane select and odd/even read
    read_planes(20'hA0005, "R4 plane select");
    cfg_odd_even = 1'b1; cfg_rd_plane = 2'd0; do_rd(20'hA0005, "R4 odd read");
    cfg_rd_plane = 2'd2; do_rd(20'hA0006, "R4 even read");
    cfg_odd_even = 1'b0;

    // R3 and R9: load latches then copy
    cfg_rd_plane = 2'd0; do_rd(20'hA0003, "R3 latch load");
    cfg_wr_mode = 2'd1; cfg_bit_mask = 8'h00; do_wr(20'hA0010, 8'hAA);
    plain_cfg(); read_planes(20'hA0010, "R9 latch copy");

    // R5 rotate and set/reset enable
    do_rd(20'hA0004, "R3 latch");
    cfg_rot = 3'd3; cfg_sr_en = 4'b0101; cfg_sr = 4'b0001; do_wr(20'hA0011, 8'h96);
    plain_cfg(); read_planes(20'hA0011, "R5 mode 0");

    // R6 logical ops
    for (int op = 1; op < 4; op++) begin
      plain_cfg(); do_rd(20'hA0002, "R3 latch");
      cfg_op = 2'(op); cfg_rot = 3'(op); do_wr(20'hA0012 + 20'(op), 8'h0F);
      plain_cfg(); read_planes(20'hA0012 + 20'(op), "R6 op");
    end

    // R7 write mode 2
    do_rd(20'hA0007, "R3 latch");
    cfg_wr_mode = 2'd2; cfg_bit_mask = 8'h3C; do_wr(20'hA0016, 8'h05);
    cfg_op = 2'd3; do_wr(20'hA0017, 8'h0A);
    plain_cfg(); read_planes(20'hA0016, "R7 mode 2");
    read_planes(20'hA0017, "R7 mode 2 xor");

    // R8 write mode 3
    do_rd(20'hA0008, "R3 latch");
    cfg_wr_mode = 2'd3; cfg_rot = 3'd1; cfg_sr = 4'b1010; cfg_bit_mask = 8'hE7;
    do_wr(20'hA0018, 8'hF0);
    plain_cfg(); read_planes(20'hA0018, "R8 mode 3");

    // R11 narrow mask keeps latch bits
    do_rd(20'hA0009, "R3 latch");
    cfg_bit_mask = 8'h81; do_wr(20'hA0019, 8'h00);
    cfg_op = 2'd2; cfg_bit_mask = 8'h18; do_wr(20'hA001A, 8'hFF);
    plain_cfg(); read_planes(20'hA0019, "R11 mask keep");
    read_planes(20'hA001A, "R11 mask keep or");

    // R10 plane mask and odd/even steering
    cfg_plane_en = 4'b0110; do_wr(20'hA001B, 8'h11);
    cfg_plane_en = 4'hF; cfg_odd_even = 1'b1;
    do_wr(20'hA001D, 8'hC3); do_wr(20'hA001E, 8'h3C);
    cfg_odd_even = 1'b0;
    read_planes(20'hA001B, "R10 plane mask");
    read_planes(20'hA001C, "R10 odd steer");
    read_planes(20'hA001E, "R10 even steer");

    // R2 windows, aliasing and misses
    cfg_map_sel = 2'd3; do_rd(20'hB8007, "R2 window 3");
    cfg_map_sel = 2'd0; do_rd(20'hB0003, "R2 window 0 alias");
    cfg_map_sel = 2'd1; do_rd(20'hA0001, "R3 latch");
    do_rd(20'hB0000, "R2 miss window 1");
    cfg_map_sel = 2'd2; do_rd(20'hB0005, "R2 miss select 2");
    do_wr(20'hA0006, 8'h77);
    cfg_map_sel = 2'd3; do_wr(20'hA0006, 8'h77);
    cfg_map_sel = 2'd1; cfg_wr_mode = 2'd1; do_wr(20'hA0020, 8'h00);
    plain_cfg();
    read_planes(20'hA0020, "R2 miss keeps latch");
    read_planes(20'hA0006, "R2 miss write dropped");

    // R12 back-to-back reads
    cfg_rd_plane = 2'd1;
    do_rd(20'hA0000, "R12 burst");
    do_rd(20'hA0001, "R12 burst");
    do_rd(20'hA0002, "R12 burst");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12 missing response", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule